// File: doc/BRIEF.md
# Circular Self-Test Ring Register

This block is a bank of flip-flops that serves two purposes. In functional operation it is an ordinary register that captures the outputs of a small piece of combinational logic fed by the system inputs and by the register itself. In self-test operation the same flip-flops are linked into a ring. Each cell takes the exclusive-OR of its functional input with the state of the cell before it, and the last cell wraps back to the first. The ring therefore produces the stimulus for the logic and compacts the logic's response into a signature, with no separate pattern generator. The feedback polynomial is x^n+1.

Software or a test controller first pulses the synchronous master clear so that every cell holds a known zero. It then raises the test mode input and issues a start pulse along with a run length. While test mode is high, the system inputs are forced to zero by AND gating, so the signature depends only on the clear value and the logic. The control section counts the requested number of ring steps. It then freezes the ring and raises `done`. The signature stays on `sigOut` so that it can be compared with a reference. The wrapped logic is a stand-in: cell i computes `x[i] ^ (q[i+1] & ~q[i+3]) ^ c[i]`, where indices are taken modulo the width and the constant c[i] is 1 when i is a multiple of 3.

Top module: `cstp_ring`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `sigOut` is all zeros and `done` is 0.
- R2: With `testMode` low and `masterClr` low, each clock loads every cell with its logic output computed from the ungated `sysIn`: q[i] <= sysIn[i] ^ (q[(i+1)%W] & ~q[(i+3)%W]) ^ (i%3==0).
- R3: During a test run, each clock sets q[i] <= f[i] ^ q[(i-1) mod W], where f is the logic output with the inputs at zero. Cell 0 takes the last cell as its predecessor and no other taps exist.
- R4: While `testMode` is high, `sysIn` has no effect. Two runs from a cleared ring with different `sysIn` patterns give the same signature.
- R5: When `masterClr` is high at a clock edge, every cell is 0 after that edge, whatever the mode or run state.
- R6: A start pulse with `testMode` high and run length N>0 causes exactly N ring steps. `done` rises on the edge of the last step.
- R7: A start pulse with run length 0 raises `done` on the next edge without stepping the ring.
- R8: While `done` is high, `testMode` stays high and no start or clear occurs, `done` remains high and `sigOut` holds. A new start pulse in this state begins a new run.
- R9: A start pulse while `testMode` is low is ignored. `done` stays 0 and the register keeps its functional behaviour.
- R10: A clock edge with `testMode` low leaves `done` at 0 and ends any run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of ring and control |
| masterClr | input | 1 | Synchronous clear of every ring cell |
| testMode | input | 1 | 1 selects self-test, 0 functional operation |
| start | input | 1 | Begins a test run when test mode is high |
| runLen | input | CNT_W | Number of ring steps for the run |
| sysIn | input | WIDTH | Functional inputs to the wrapped logic |
| sigOut | output | WIDTH | Register state, and the signature when done |
| done | output | 1 | Run finished, signature frozen |

## Verification
On every cycle, the assertions check that a master clear empties the ring, that the ring holds while test mode is idle or done, that a zero-length run finishes at once, and that dropping test mode clears `done`. Some behaviours can only be shown by the bench's scenarios: the exact signature value after many XOR ring steps, the exact count of steps before `done`, and the independence of the signature from `sysIn`. The bench shows these by comparing against a cycle-level model, and by repeating a run with different input patterns.

// File: rtl/cstp_pkg.sv
package cstp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_t;

  // strobes from the control section to the ring datapath
  typedef struct packed {
    logic clr;   // synchronous master clear
    logic step;  // one circular self-test step
    logic load;  // functional capture
    logic gate;  // force system inputs to zero
  } strobe_t;

endpackage

// File: rtl/cstp_cut.sv
// Stand-in combinational logic wrapped by the ring.
module cstp_cut #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] qIn,
  output logic [WIDTH-1:0] fOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int NB1 = (i + 1) % WIDTH;
    localparam int NB3 = (i + 3) % WIDTH;
    localparam logic INV = ((i % 3) == 0);
    assign fOut[i] = xIn[i] ^ (qIn[NB1] & ~qIn[NB3]) ^ INV;
  end
endmodule

// File: rtl/cstp_ctrl.sv
module cstp_ctrl
  import cstp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterClr,
  input  logic             testMode,
  input  logic             start,
  input  logic [CNT_W-1:0] runLen,
  output strobe_t          strb,
  output logic             done,
  output logic             running
);
  ctrl_state_t state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!testMode) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            if (runLen == '0) begin
              state <= ST_DONE;
            end else begin
              state <= ST_RUN;
              cnt   <= runLen;
            end
          end
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign running   = (state == ST_RUN);
  assign done      = (state == ST_DONE);
  assign strb.clr  = masterClr;
  assign strb.step = testMode && running;
  assign strb.load = !testMode;
  assign strb.gate = testMode;
endmodule

// File: rtl/cstp_datapath.sv
module cstp_datapath
  import cstp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] sysIn,
  output logic [WIDTH-1:0] qOut
);
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] gatedIn;
  logic [WIDTH-1:0] funcD;
  logic [WIDTH-1:0] ringD;

  // AND gating isolates the system inputs during self-test
  assign gatedIn = sysIn & {WIDTH{~strb.gate}};

  cstp_cut #(.WIDTH(WIDTH)) uCut (
    .xIn (gatedIn),
    .qIn (q),
    .fOut(funcD)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    localparam int PREV = (i + WIDTH - 1) % WIDTH;
    assign ringD[i] = funcD[i] ^ q[PREV];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          q <= '0;
    else if (strb.clr)  q <= '0;
    else if (strb.step) q <= ringD;
    else if (strb.load) q <= funcD;
  end

  assign qOut = q;
endmodule

// File: rtl/cstp_ring.sv
module cstp_ring
  import cstp_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterClr,
  input  logic             testMode,
  input  logic             start,
  input  logic [CNT_W-1:0] runLen,
  input  logic [WIDTH-1:0] sysIn,
  output logic [WIDTH-1:0] sigOut,
  output logic             done
);
  strobe_t strb;
  logic    running;

  cstp_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .masterClr(masterClr),
    .testMode (testMode),
    .start    (start),
    .runLen   (runLen),
    .strb     (strb),
    .done     (done),
    .running  (running)
  );

  cstp_datapath #(.WIDTH(WIDTH)) uDp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .sysIn(sysIn),
    .qOut (sigOut)
  );
endmodule

// File: rtl/cstp_ring_chk.sv
module cstp_ring_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             masterClr,
  input logic             testMode,
  input logic             start,
  input logic [CNT_W-1:0] runLen,
  input logic [WIDTH-1:0] sigOut,
  input logic             done,
  input logic             running
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> (sigOut == '0)); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && testMode && !start && !masterClr) |=> (done && $stable(sigOut))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !running && !done && !start && !masterClr) |=> $stable(sigOut)); // R4

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !running && start && (runLen == '0) && !masterClr) |=> (done && $stable(sigOut))); // R7

  AST_NORMAL_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |=> (!done && !running)); // R10

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(done && running)); // R6
endmodule

bind cstp_ring cstp_ring_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .masterClr(masterClr),
  .testMode (testMode),
  .start    (start),
  .runLen   (runLen),
  .sigOut   (sigOut),
  .done     (done),
  .running  (running)
);

// File: tb/tb_cstp_ring.sv
`timescale 1ns/1ps
module tb_cstp_ring;
  localparam int W  = 8;
  localparam int CW = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterClr = 1'b0, testMode = 1'b0, start = 1'b0;
  logic [CW-1:0] runLen = '0;
  logic [W-1:0]  sysIn = '0;
  logic [W-1:0]  sigOut;
  logic          done;

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0;

  // bench model: 0 idle, 1 run, 2 done
  logic [W-1:0]  mQ = '0;
  int            mState = 0;
  logic [CW-1:0] mCnt = '0;

  always #2.5 clk = ~clk;

  cstp_ring #(.WIDTH(W), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .masterClr(masterClr), .testMode(testMode),
    .start(start), .runLen(runLen), .sysIn(sysIn), .sigOut(sigOut), .done(done)
  );

  function automatic logic [W-1:0] cutF(logic [W-1:0] x, logic [W-1:0] q);
    logic [W-1:0] f;
    for (int i = 0; i < W; i++)
      f[i] = x[i] ^ (q[(i+1)%W] & ~q[(i+3)%W]) ^ ((i % 3) == 0);
    return f;
  endfunction

  function automatic logic [W-1:0] ringF(logic [W-1:0] f, logic [W-1:0] q);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = f[i] ^ q[(i+W-1)%W];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] gotQ, logic [W-1:0] expQ,
                       logic gotD, logic expD);
    compared++;
    if (gotQ !== expQ || gotD !== expD) begin
      mismatched++;
      $display("FAIL %s: sigOut=%h done=%b expected sigOut=%h done=%b",
               tag, gotQ, gotD, expQ, expD);
    end
  endtask

  // one clock with the inputs as set; model advances and outputs are compared
  task automatic cyc();
    logic [W-1:0] f, nq;
    int ns;
    logic [CW-1:0] nc;
    string tag;
    f = cutF(testMode ? '0 : sysIn, mQ);
    if (masterClr) nq = '0;
    else if (testMode && mState == 1) nq = ringF(f, mQ);
    else if (!testMode) nq = f;
    else nq = mQ;
    ns = mState; nc = mCnt;
    if (!testMode) ns = 0;
    else if (mState == 1) begin
      nc = mCnt - 1'b1;
      if (mCnt == 1) ns = 2;
    end else if (start) begin
      if (runLen == 0) ns = 2;
      else begin ns = 1; nc = runLen; end
    end
    if (masterClr) tag = "R5";
    else if (!testMode) tag = start ? "R9" : (mState != 0 ? "R10" : "R2");
    else if (mState == 1) tag = (ns == 2) ? "R6" : "R3";
    else if (mState == 2) tag = start ? "R8 restart" : "R8";
    else if (start && runLen == 0) tag = "R7";
    else tag = "R4";
    @(posedge clk);
    mQ = nq; mState = ns; mCnt = nc;
    #1;
    check(tag, sigOut, mQ, done, (mState == 2));
  endtask

  task automatic runTest(int len, bit randIn);
    testMode = 1'b1; start = 1'b1; runLen = CW'(len);
    cyc();
    start = 1'b0;
    for (int k = 0; k < len + 2; k++) begin
      if (randIn) sysIn = W'($urandom);
      cyc();
    end
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] sigA, sigB;
    void'($urandom(32'h5eed_c57b));
    sysIn = 8'h5a;
    #1;
    check("R1 in reset", sigOut, '0, done, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    // first clock after reset, in normal mode sysIn=0 -> f from zero state
    sysIn = '0;
    cyc(); // R1 follow-up via model (R2 path)

    // R2: functional loading with random inputs
    for (int k = 0; k < 40; k++) begin sysIn = W'($urandom); cyc(); end

    // R5: clear in functional mode
    masterClr = 1'b1; sysIn = 8'hff; cyc(); masterClr = 1'b0;

    // R9: start ignored while test mode low
    start = 1'b1; runLen = 16'd3; cyc(); start = 1'b0;
    for (int k = 0; k < 4; k++) begin sysIn = W'($urandom); cyc(); end

    // R4: two runs from a cleared ring, different input activity
    masterClr = 1'b1; cyc(); masterClr = 1'b0;
    runTest(37, 1'b0);
    sigA = sigOut;
    testMode = 1'b0; cyc();               // R10: done drops
    masterClr = 1'b1; cyc(); masterClr = 1'b0;
    testMode = 1'b1; sysIn = 8'h00; cyc();
    runTest(37, 1'b1);
    sigB = sigOut;
    check("R4 same signature", sigB, sigA, done, 1'b1);

    // R8: hold then restart
    for (int k = 0; k < 6; k++) begin sysIn = W'($urandom); cyc(); end
    runTest(5, 1'b1);

    // R7: zero length
    runTest(0, 1'b1);

    // R5: clear during a run
    testMode = 1'b1; start = 1'b1; runLen = 16'd20; cyc(); start = 1'b0;
    for (int k = 0; k < 5; k++) cyc();
    masterClr = 1'b1; cyc(); masterClr = 1'b0;
    for (int k = 0; k < 20; k++) cyc();

    // R10: test mode dropped mid-run
    start = 1'b1; runLen = 16'd50; cyc(); start = 1'b0;
    for (int k = 0; k < 8; k++) cyc();
    testMode = 1'b0; cyc();
    testMode = 1'b1; cyc();

    // long run, R6
    masterClr = 1'b1; cyc(); masterClr = 1'b0;
    runTest(300, 1'b1);

    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      masterClr = (r < 3);
      testMode  = (r >= 10) ? 1'b1 : (($urandom_range(0, 1) == 1) ? 1'b1 : 1'b0);
      start     = ($urandom_range(0, 19) == 0);
      runLen    = ($urandom_range(0, 7) == 0) ? '0 : CW'($urandom_range(1, 60));
      sysIn     = W'($urandom);
      cyc();
    end
    masterClr = 1'b0; start = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule